// File: doc/BRIEF.md
# FSK Edge-Interval Bit Demodulator

This block turns a stream of 8-bit envelope samples from a low-frequency reader front end into a serial stream of data bits. It compares each accepted sample with a fixed level to get a two-level signal. Only rising crossings of that signal matter. The distance between two successive rising crossings, counted in accepted samples, is a subcarrier period. A short period gives symbol 1 and a long period gives symbol 0.

A second stage groups consecutive equal symbols into runs. When the symbol value changes, the run that just ended becomes a number of data bits. The run length plus one is divided by a divisor chosen for the run's polarity. A quotient of zero is raised to one. A run whose bit count is at or above a programmable ceiling is dropped, because it has no valid encoding.

The surviving bits carry the polarity of their run and leave one per clock on `bit_data`, qualified by `bit_valid`. The two divisors and the ceiling are quasi-static configuration inputs. The block reads them at the moment a run ends.

Top module: `fsk_bit_demod`

## Requirements
- R1: An accepted sample counts as high when its value is 127 or more and as low when it is 126 or less.
- R2: A symbol is produced only at a low-to-high change between two accepted samples. The first accepted sample after reset only sets the previous level. The first rising change after reset only sets the interval reference and produces no symbol.
- R3: The interval of a rising change is the number of accepted samples since the previous rising change, saturating at 255. The symbol is 1 when the interval is 8 or less and 0 when it is 9 or more.
- R4: When a symbol differs from the current run's polarity, the run ends. Its bit count is the integer quotient of (run length + 1) by `div_one` for a run of 1 symbols, or by `div_zero` for a run of 0 symbols. A divisor of 0 acts as 1.
- R5: A computed bit count of 0 is raised to 1.
- R6: A run whose bit count is equal to or greater than `max_bits` produces no output bits.
- R7: A kept run produces exactly its bit count of output bits, each equal to the run's polarity, on consecutive cycles. The first of these bits is valid in the cycle after the third rising clock edge, counting the edge that accepts the sample whose rising change ended the run as the first.
- R8: Reset forces `bit_valid` low and discards any run in progress, the interval reference and the previous level.
- R9: Cycles with `smp_valid` low have no effect, whatever `smp_data` holds.
- R10: A run that has not been ended by a symbol of the other polarity produces no bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 8 | Envelope sample |
| div_one | input | 4 | Run-length divisor for runs of 1 symbols |
| div_zero | input | 4 | Run-length divisor for runs of 0 symbols |
| max_bits | input | 4 | Bit count at or above which a run is dropped |
| bit_valid | output | 1 | One pulse per emitted data bit |
| bit_data | output | 1 | Emitted data bit |

## Verification
The bench sweeps every pair of divisors from 0 to 4 against several ceilings. One sweep value is a zero divisor, which a design that divided by the raw input would reject or turn into garbage. Another is a run short enough that its quotient is zero, which would vanish if the count were not raised to one. Directed streams target the off-by-one spots:
- Samples of exactly 126 and 127. A slicer with the wrong comparison loses every edge.
- Intervals of exactly 8 and 9. A shifted short/long boundary flips symbols.
- A gap of 264 samples. A wrapping counter would see 8 and call it short.
- A run cut off by reset. State that survives reset would produce a spurious burst.

Idle cycles filled with extreme sample values expose a design that samples without its qualifier. The cycle of the first bit of each configuration is checked against the three-register latency.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } run_pol_e;

   localparam int unsigned POL_COUNT = 2;

endpackage

// File: rtl/fsk_edge_interval.sv
module fsk_edge_interval #(
   parameter int unsigned SMP_W       = 8,
   parameter int unsigned SLICE_LEVEL = 127,
   parameter int unsigned SHORT_LIMIT = 9,
   parameter int unsigned IVL_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             sym_valid,
   output logic             sym_bit
);

   localparam logic [IVL_W-1:0] IVL_TOP   = {IVL_W{1'b1}};
   localparam logic [SMP_W-1:0] LEVEL_CMP = SMP_W'(SLICE_LEVEL);
   localparam logic [IVL_W-1:0] SHORT_CMP = IVL_W'(SHORT_LIMIT);

   if (SLICE_LEVEL >= (1 << SMP_W)) begin : g_bad_level
      $error("fsk_edge_interval: SLICE_LEVEL does not fit SMP_W");
   end
   if (SHORT_LIMIT == 0 || SHORT_LIMIT > (1 << IVL_W) - 1) begin : g_bad_limit
      $error("fsk_edge_interval: SHORT_LIMIT out of counter range");
   end

   logic             primed_q;
   logic             have_ref_q;
   logic             prev_lvl_q;
   logic [IVL_W-1:0] ivl_q;
   logic             lvl;
   logic             rising;
   logic [IVL_W-1:0] ivl_inc;

   always_comb begin
      lvl     = (smp_data >= LEVEL_CMP);
      rising  = primed_q & ~prev_lvl_q & lvl;
      ivl_inc = (ivl_q == IVL_TOP) ? ivl_q : ivl_q + IVL_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q   <= 1'b0;
         have_ref_q <= 1'b0;
         prev_lvl_q <= 1'b0;
         ivl_q      <= '0;
         sym_valid  <= 1'b0;
         sym_bit    <= 1'b0;
      end else begin
         sym_valid <= 1'b0;
         if (smp_valid) begin
            primed_q   <= 1'b1;
            prev_lvl_q <= lvl;
            if (rising) begin
               ivl_q      <= '0;
               have_ref_q <= 1'b1;
               sym_valid  <= have_ref_q;
               sym_bit    <= (ivl_inc < SHORT_CMP);
            end else begin
               ivl_q <= ivl_inc;
            end
         end
      end
   end

endmodule

// File: rtl/fsk_run_collapse.sv
module fsk_run_collapse
   import fsk_demod_pkg::*;
#(
   parameter int unsigned RUN_W = 8,
   parameter int unsigned CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic             sym_bit,
   input  logic [CFG_W-1:0] div_one,
   input  logic [CFG_W-1:0] div_zero,
   input  logic [CFG_W-1:0] max_bits,
   output logic             burst_valid,
   output logic             burst_pol,
   output logic [CFG_W-1:0] burst_cnt
);

   localparam int unsigned     Q_W     = RUN_W + 1;
   localparam logic [RUN_W-1:0] RUN_TOP = {RUN_W{1'b1}};

   if (CFG_W > Q_W) begin : g_bad_cfg
      $error("fsk_run_collapse: CFG_W wider than the quotient");
   end

   logic             have_run_q;
   run_pol_e         run_pol_q;
   logic [RUN_W-1:0] run_len_q;
   logic [Q_W-1:0]   len_plus;
   logic [Q_W-1:0]   quot_fix [POL_COUNT];
   logic [Q_W-1:0]   sel_q;
   logic             keep_run;
   logic [RUN_W-1:0] len_inc;

   assign len_plus = {1'b0, run_len_q} + Q_W'(1);
   assign len_inc  = (run_len_q == RUN_TOP) ? run_len_q : run_len_q + RUN_W'(1);

   for (genvar p = 0; p < POL_COUNT; p++) begin : g_pol
      logic [CFG_W-1:0] div_raw;
      logic [Q_W-1:0]   div_eff;
      logic [Q_W-1:0]   quot;
      assign div_raw     = (p == 1) ? div_one : div_zero;
      assign div_eff     = (div_raw == '0) ? Q_W'(1) : Q_W'(div_raw);
      assign quot        = len_plus / div_eff;
      assign quot_fix[p] = (quot == '0) ? Q_W'(1) : quot;
   end

   always_comb begin
      sel_q    = (run_pol_q == POL_HIGH) ? quot_fix[1] : quot_fix[0];
      keep_run = (sel_q < Q_W'(max_bits));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_run_q  <= 1'b0;
         run_pol_q   <= POL_LOW;
         run_len_q   <= '0;
         burst_valid <= 1'b0;
         burst_pol   <= 1'b0;
         burst_cnt   <= '0;
      end else begin
         burst_valid <= 1'b0;
         if (sym_valid) begin
            if (!have_run_q) begin
               have_run_q <= 1'b1;
               run_pol_q  <= run_pol_e'(sym_bit);
               run_len_q  <= RUN_W'(1);
            end else if (sym_bit == run_pol_q) begin
               run_len_q <= len_inc;
            end else begin
               burst_valid <= keep_run;
               burst_pol   <= run_pol_q;
               burst_cnt   <= sel_q[CFG_W-1:0];
               run_pol_q   <= run_pol_e'(sym_bit);
               run_len_q   <= RUN_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/fsk_bit_serial.sv
module fsk_bit_serial #(
   parameter int unsigned CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             burst_valid,
   input  logic             burst_pol,
   input  logic [CFG_W-1:0] burst_cnt,
   output logic             bit_valid,
   output logic             bit_data,
   output logic             busy
);

   logic [CFG_W-1:0] rem_q;

   assign busy = (rem_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q     <= '0;
         bit_valid <= 1'b0;
         bit_data  <= 1'b0;
      end else if (burst_valid) begin
         rem_q     <= burst_cnt - CFG_W'(1);
         bit_valid <= 1'b1;
         bit_data  <= burst_pol;
      end else if (rem_q != '0) begin
         rem_q     <= rem_q - CFG_W'(1);
         bit_valid <= 1'b1;
      end else begin
         bit_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/fsk_bit_demod.sv
module fsk_bit_demod #(
   parameter int unsigned SMP_W       = 8,
   parameter int unsigned SLICE_LEVEL = 127,
   parameter int unsigned SHORT_LIMIT = 9,
   parameter int unsigned IVL_W       = 8,
   parameter int unsigned RUN_W       = 8,
   parameter int unsigned CFG_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [CFG_W-1:0] div_one,
   input  logic [CFG_W-1:0] div_zero,
   input  logic [CFG_W-1:0] max_bits,
   output logic             bit_valid,
   output logic             bit_data
);

   if (SMP_W < 2 || IVL_W < 2 || RUN_W < 2 || CFG_W < 2) begin : g_bad_width
      $error("fsk_bit_demod: widths must be at least 2");
   end

   logic             sym_valid;
   logic             sym_bit;
   logic             burst_valid;
   logic             burst_pol;
   logic [CFG_W-1:0] burst_cnt;
   logic             ser_busy;

   fsk_edge_interval #(
      .SMP_W       (SMP_W),
      .SLICE_LEVEL (SLICE_LEVEL),
      .SHORT_LIMIT (SHORT_LIMIT),
      .IVL_W       (IVL_W)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .sym_valid (sym_valid),
      .sym_bit   (sym_bit)
   );

   fsk_run_collapse #(
      .RUN_W (RUN_W),
      .CFG_W (CFG_W)
   ) u_runs (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_valid   (sym_valid),
      .sym_bit     (sym_bit),
      .div_one     (div_one),
      .div_zero    (div_zero),
      .max_bits    (max_bits),
      .burst_valid (burst_valid),
      .burst_pol   (burst_pol),
      .burst_cnt   (burst_cnt)
   );

   fsk_bit_serial #(
      .CFG_W (CFG_W)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .burst_valid (burst_valid),
      .burst_pol   (burst_pol),
      .burst_cnt   (burst_cnt),
      .bit_valid   (bit_valid),
      .bit_data    (bit_data),
      .busy        (ser_busy)
   );

endmodule

// File: rtl/fsk_bit_demod_chk.sv
module fsk_bit_demod_chk #(
   parameter int unsigned CFG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic [CFG_W-1:0] max_bits,
   input logic             sym_valid,
   input logic             burst_valid,
   input logic [CFG_W-1:0] burst_cnt,
   input logic             ser_busy,
   input logic             bit_valid,
   input logic             bit_data
);

   AST_SYM_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |-> $past(smp_valid)); // R2

   AST_BURST_AFTER_SYM: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> $past(sym_valid)); // R4

   AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> (burst_cnt != '0)); // R5

   AST_BURST_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> (burst_cnt < max_bits)); // R6

   AST_BITS_START_ON_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_valid) |-> $past(burst_valid)); // R7

   AST_BIT_HOLDS_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && $past(bit_valid) && !$past(burst_valid)) |-> $stable(bit_data)); // R7

   AST_NO_BURST_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> !ser_busy); // R7

endmodule

bind fsk_bit_demod fsk_bit_demod_chk #(.CFG_W(CFG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .max_bits    (max_bits),
   .sym_valid   (sym_valid),
   .burst_valid (burst_valid),
   .burst_cnt   (burst_cnt),
   .ser_busy    (ser_busy),
   .bit_valid   (bit_valid),
   .bit_data    (bit_data)
);

// File: tb/fsk_bit_demod_tb.sv
module fsk_bit_demod_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic [7:0] smp_data = 8'd0;
   logic [3:0] div_one = 4'd1;
   logic [3:0] div_zero = 4'd1;
   logic [3:0] max_bits = 4'd15;
   logic       bit_valid;
   logic       bit_data;

   int n_vec = 0;
   int n_bad = 0;
   int edge_cnt = 0;
   int first_bit_edge = -1;
   int exp_first_idx = -1;
   int stim[$];
   int acc_edge[$];
   bit expq[$];
   bit gotq[$];

   always #5 clk = ~clk;

   fsk_bit_demod u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .div_one   (div_one),
      .div_zero  (div_zero),
      .max_bits  (max_bits),
      .bit_valid (bit_valid),
      .bit_data  (bit_data)
   );

   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   always @(negedge clk) begin
      if (bit_valid) begin
         gotq.push_back(bit_data);
         if (first_bit_edge < 0) first_bit_edge = edge_cnt;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n     = 1'b0;
      smp_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      gotq.delete();
      first_bit_edge = -1;
   endtask

   task automatic add_period(input int p, input int lo, input int hi);
      for (int i = 0; i < p; i++) stim.push_back((i < p / 2) ? lo : hi);
   endtask

   task automatic add_run(input int p, input int k, input int lo, input int hi);
      for (int i = 0; i < k; i++) add_period(p, lo, hi);
   endtask

   // Expected stream from R1..R6, R10
   task automatic model(input int d1, input int d0, input int mx);
      bit primed = 0, prev = 0, have_ref = 0, have_run = 0, pol = 0, lvl, sym;
      int cnt = 0, len = 0, q, d;
      expq.delete();
      exp_first_idx = -1;
      for (int i = 0; i < stim.size(); i++) begin
         lvl = (stim[i] >= 127);
         if (!primed) begin
            primed = 1; prev = lvl;
            continue;
         end
         cnt = (cnt >= 255) ? 255 : cnt + 1;
         if (!prev && lvl) begin
            if (have_ref) begin
               sym = (cnt <= 8);
               if (!have_run) begin
                  have_run = 1; pol = sym; len = 1;
               end else if (sym == pol) begin
                  len = (len >= 255) ? 255 : len + 1;
               end else begin
                  d = pol ? d1 : d0;
                  if (d == 0) d = 1;
                  q = (len + 1) / d;
                  if (q == 0) q = 1;
                  if (q < mx) begin
                     if (exp_first_idx < 0) exp_first_idx = i;
                     for (int j = 0; j < q; j++) expq.push_back(pol);
                  end
                  pol = sym; len = 1;
               end
            end
            have_ref = 1;
            cnt = 0;
         end
         prev = lvl;
      end
   endtask

   task automatic drive(input int gap, input bit junk);
      acc_edge.delete();
      for (int i = 0; i < stim.size(); i++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_data  = 8'(stim[i]);
         acc_edge.push_back(edge_cnt + 1);
         for (int g = 1; g < gap; g++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            if (junk) smp_data = (g % 2) ? 8'd255 : 8'd0;
         end
      end
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic compare(input string req, input bit chk_lat);
      int n;
      check(gotq.size() == expq.size(), req, "bit count", gotq.size(), expq.size());
      n = (gotq.size() < expq.size()) ? gotq.size() : expq.size();
      for (int i = 0; i < n; i++)
         check(gotq[i] == expq[i], req, $sformatf("bit %0d", i), gotq[i], expq[i]);
      if (chk_lat && exp_first_idx >= 0)
         check(first_bit_edge == acc_edge[exp_first_idx] + 2, "R7", "first bit edge",
               first_bit_edge, acc_edge[exp_first_idx] + 2);
   endtask

   task automatic run_cfg(input string req, input int d1, input int d0, input int mx,
                          input int gap, input bit junk);
      div_one  = 4'(d1);
      div_zero = 4'(d0);
      max_bits = 4'(mx);
      do_reset();
      model(d1, d0, mx);
      drive(gap, junk);
      compare(req, 1'b1);
   endtask

   task automatic build_sweep();
      stim.delete();
      for (int r = 1; r <= 6; r++) begin
         add_run(3, r, 40, 200);
         add_run(10, r, 40, 200);
      end
      add_run(3, 1, 40, 200);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R8: reset state
      do_reset();
      check(bit_valid == 1'b0, "R8", "bit_valid after reset", bit_valid, 0);

      // R4 R5 R6 R7: divisor and ceiling sweep, zero divisors included
      build_sweep();
      for (int d1 = 0; d1 <= 4; d1++)
         for (int d0 = 0; d0 <= 4; d0++)
            for (int m = 0; m < 3; m++)
               run_cfg("R4", d1, d0, (m == 0) ? 2 : (m == 1) ? 5 : 8, 4, 1'b0);

      // R1: slicing boundary 126 / 127
      stim.delete();
      add_run(3, 2, 126, 127); add_run(10, 3, 126, 127);
      add_run(3, 2, 126, 127); add_run(10, 1, 126, 127);
      run_cfg("R1", 1, 1, 8, 4, 1'b0);
      check(gotq.size() > 0, "R1", "bits seen at 126/127", gotq.size(), expq.size());

      // R3: interval boundary 8 / 9
      stim.delete();
      add_run(8, 3, 40, 200); add_run(9, 2, 40, 200);
      add_run(8, 1, 40, 200); add_run(9, 4, 40, 200); add_run(8, 2, 40, 200);
      run_cfg("R3", 1, 1, 15, 8, 1'b0);

      // R3: interval saturation (264 samples would wrap to 8)
      stim.delete();
      add_run(3, 3, 40, 200);
      for (int i = 0; i < 262; i++) stim.push_back(40);
      stim.push_back(200);
      add_run(3, 3, 40, 200); add_run(10, 2, 40, 200); add_run(3, 1, 40, 200);
      run_cfg("R3", 1, 1, 15, 8, 1'b0);

      // R9: idle cycles carry extreme junk
      build_sweep();
      run_cfg("R9", 2, 3, 8, 6, 1'b1);

      // R10: run never ended
      stim.delete();
      add_run(3, 6, 40, 200);
      run_cfg("R10", 1, 1, 15, 4, 1'b0);
      check(gotq.size() == 0, "R10", "bits from open run", gotq.size(), 0);

      // R8: reset mid-run discards the open run and the reference
      div_one = 4'd1; div_zero = 4'd1; max_bits = 4'd15;
      do_reset();
      stim.delete();
      add_run(3, 4, 40, 200);
      drive(4, 1'b0);
      do_reset();
      stim.delete();
      add_run(10, 3, 40, 200); add_run(3, 2, 40, 200); add_run(10, 1, 40, 200);
      model(1, 1, 15);
      drive(8, 1'b0);
      compare("R8", 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule